// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the configuration header of a PCI-to-PCI bridge: bus numbers, the secondary latency timer, command and bridge-control registers, and the I/O, memory and prefetchable-memory base/limit fields. Configuration software reaches it through dword-addressed accesses with a 4-bit byte enable. Each write takes effect at the next clock edge. Reads return the current contents of the addressed dword as a combinational function of the address.

The register values are also exported as decoded forwarding windows and control fields to a separate window decoder. After any write whose enabled byte lanes fall on a register that shapes those windows, the block raises a one-cycle update pulse. It raises a secondary-bus reset pulse only when the bus-reset control bit goes from 0 to 1. A separate request loads a "forwarding disabled" state in which every base sits above its limit.

Top module: `pcib_cfg_regs`

## Requirements
- R1: After a synchronous reset the following are all zero: the primary, secondary and subordinate bus numbers, the secondary latency timer, the command register, the bridge-control register, the address bits of every base/limit field, and the upper halves of the prefetchable base and limit. The type nibbles still read as their fixed values.
- R2: When `fwd_disable` is high at a clock edge, the next cycle shows the following: all base address bits are ones, all limit address bits are zero, and both prefetchable upper dwords are zero. A write in the same cycle to those fields is overridden.
- R3: A write changes only the bytes whose `cfg_be` bit is set. Bit i of `cfg_be` enables byte offset 4*`cfg_addr`+i, which takes data bits [8i+7:8i].
- R4: Several fields are read-only. The status words at bytes 0x06 and 0x1E read 0x00A0 (66 MHz and fast back-to-back capable). Bytes 0x09..0x0B read 0x060400. Byte 0x0E reads 0x01, with bit 7 equal to the MULTI_FN parameter. The I/O base/limit low nibbles read 1 when IO_32BIT is set, otherwise 0. The prefetchable base/limit low nibbles read 1 when PREF_64BIT is set, otherwise 0. The memory base/limit low nibbles read 0. Only command bits 0x0547 and bridge-control bits 0x007F are writable, so the palette-snoop bit 5 of the command register reads zero. Unimplemented offsets read zero.
- R5: `win_update` is high for exactly the cycle after a write edge in which an enabled byte lane falls on any of these byte offsets: 0x04-0x05, 0x1C-0x1D, 0x20-0x33 or 0x3E-0x3F. It is low otherwise, including for writes with no enabled lane.
- R6: `sec_bus_rst` is high for exactly the cycle after a write that takes bridge-control bit 6 (byte 0x3E bit 6, data bit 22 at dword 15) from 0 to 1. Writing 1 while the bit is already 1 gives no pulse.
- R7: Each decoded window is built from its register fields as follows:
  - I/O base = {upper16 if IO_32BIT else 0, base[7:4], 0x000}; I/O limit uses the same form with low bits 0xFFF.
  - Memory base = {base[15:4], 20'h0}; memory limit uses the same form with low bits 0xFFFFF.
  - Prefetchable base and limit use the same form, with the upper dword included if PREF_64BIT.
  - The bus numbers, latency, command and bridge-control outputs equal their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 4 | Dword index into the 64-byte header (read and write) |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| fwd_disable | input | 1 | Load the forwarding-disabled base/limit state |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| win_update | output | 1 | Pulse after a write touching window registers |
| sec_bus_rst | output | 1 | Pulse on rising edge of the bus-reset control bit |
| bus_pri | output | 8 | Primary bus number |
| bus_sec | output | 8 | Secondary bus number |
| bus_sub | output | 8 | Subordinate bus number |
| sec_lat | output | 8 | Secondary latency timer |
| cmd_reg | output | 16 | Command register |
| bctl_reg | output | 16 | Bridge-control register |
| io_base | output | 32 | Decoded I/O window base |
| io_limit | output | 32 | Decoded I/O window limit |
| mem_base | output | 32 | Decoded memory window base |
| mem_limit | output | 32 | Decoded memory window limit |
| pref_base | output | 64 | Decoded prefetchable window base |
| pref_limit | output | 64 | Decoded prefetchable window limit |

## Verification
Read data depends on the address with no latency. Register contents, decoded windows and both pulses are due in the cycle right after the clock edge that accepts a write or a disable request. The bench drives stimulus 1 ns after each rising edge and samples at the falling edge. Its behavioural byte-array model is updated at the same rising edge as the design. Every cycle, it therefore compares read data, pulses and windows for the cycle those values belong to.

// File: rtl/pcib_cfg_pkg.sv
// Shared constants and register type for the bridge configuration header.
// Assumes a 64-byte header addressed as 16 dwords.
package pcib_cfg_pkg;

    localparam int HDR_DWORDS = 16;
    localparam int DW_AW      = $clog2(HDR_DWORDS);
    localparam int BYTE_AW    = DW_AW + 2;

    typedef logic [DW_AW-1:0] dw_idx_t;

    localparam dw_idx_t DW_CMD   = dw_idx_t'(1);
    localparam dw_idx_t DW_CLASS = dw_idx_t'(2);
    localparam dw_idx_t DW_HDR   = dw_idx_t'(3);
    localparam dw_idx_t DW_BUS   = dw_idx_t'(6);
    localparam dw_idx_t DW_IO    = dw_idx_t'(7);
    localparam dw_idx_t DW_MEM   = dw_idx_t'(8);
    localparam dw_idx_t DW_PREF  = dw_idx_t'(9);
    localparam dw_idx_t DW_PBUP  = dw_idx_t'(10);
    localparam dw_idx_t DW_PLUP  = dw_idx_t'(11);
    localparam dw_idx_t DW_IOUP  = dw_idx_t'(12);
    localparam dw_idx_t DW_BCTL  = dw_idx_t'(15);

    localparam logic [15:0] CMD_WMASK   = 16'h0547;
    localparam logic [15:0] BCTL_WMASK  = 16'h007F;
    localparam logic [15:0] STATUS_CAPS = 16'h00A0;
    localparam logic [23:0] CLASS_P2P   = 24'h060400;
    localparam int          SBR_BIT     = 6;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  pri;
        logic [7:0]  sec;
        logic [7:0]  sub;
        logic [7:0]  lat;
        logic [3:0]  io_base_a;
        logic [3:0]  io_lim_a;
        logic [11:0] mem_base_a;
        logic [11:0] mem_lim_a;
        logic [11:0] pref_base_a;
        logic [11:0] pref_lim_a;
        logic [31:0] pref_base_up;
        logic [31:0] pref_lim_up;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [15:0] bctl;
    } bridge_regs_t;

    // True when a byte offset belongs to a register that shapes a forwarding window.
    function automatic logic lane_in_window(input logic [BYTE_AW-1:0] off);
        return (off[BYTE_AW-1:1] == 5'h02) ||
               (off[BYTE_AW-1:1] == 5'h0E) ||
               (off >= 6'h20 && off <= 6'h33) ||
               (off[BYTE_AW-1:1] == 5'h1F);
    endfunction

endpackage

// File: rtl/pcib_cfg_store.sv
// Register storage for the bridge header. Applies byte-enabled writes and the
// forwarding-disable request (which wins over a same-cycle write).
// Assumes synchronous active-low reset; write masks come from the package.
module pcib_cfg_store
    import pcib_cfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  dw_idx_t      wr_addr,
    input  logic [3:0]   wr_be,
    input  logic [31:0]  wr_data,
    input  logic         fwd_disable,
    output bridge_regs_t regs
);

    bridge_regs_t nxt;

    // Next-state: per-lane write merge followed by the disable override.
    always_comb begin
        nxt = regs;
        if (wr_en) begin
            unique case (wr_addr)
                DW_CMD: begin
                    if (wr_be[0]) nxt.cmd[7:0]  = wr_data[7:0]  & CMD_WMASK[7:0];
                    if (wr_be[1]) nxt.cmd[15:8] = wr_data[15:8] & CMD_WMASK[15:8];
                end
                DW_BUS: begin
                    if (wr_be[0]) nxt.pri = wr_data[7:0];
                    if (wr_be[1]) nxt.sec = wr_data[15:8];
                    if (wr_be[2]) nxt.sub = wr_data[23:16];
                    if (wr_be[3]) nxt.lat = wr_data[31:24];
                end
                DW_IO: begin
                    if (wr_be[0]) nxt.io_base_a = wr_data[7:4];
                    if (wr_be[1]) nxt.io_lim_a  = wr_data[15:12];
                end
                DW_MEM: begin
                    if (wr_be[0]) nxt.mem_base_a[3:0]  = wr_data[7:4];
                    if (wr_be[1]) nxt.mem_base_a[11:4] = wr_data[15:8];
                    if (wr_be[2]) nxt.mem_lim_a[3:0]   = wr_data[23:20];
                    if (wr_be[3]) nxt.mem_lim_a[11:4]  = wr_data[31:24];
                end
                DW_PREF: begin
                    if (wr_be[0]) nxt.pref_base_a[3:0]  = wr_data[7:4];
                    if (wr_be[1]) nxt.pref_base_a[11:4] = wr_data[15:8];
                    if (wr_be[2]) nxt.pref_lim_a[3:0]   = wr_data[23:20];
                    if (wr_be[3]) nxt.pref_lim_a[11:4]  = wr_data[31:24];
                end
                DW_PBUP: begin
                    for (int i = 0; i < 4; i++)
                        if (wr_be[i]) nxt.pref_base_up[8*i +: 8] = wr_data[8*i +: 8];
                end
                DW_PLUP: begin
                    for (int i = 0; i < 4; i++)
                        if (wr_be[i]) nxt.pref_lim_up[8*i +: 8] = wr_data[8*i +: 8];
                end
                DW_IOUP: begin
                    if (wr_be[0]) nxt.io_base_up[7:0]  = wr_data[7:0];
                    if (wr_be[1]) nxt.io_base_up[15:8] = wr_data[15:8];
                    if (wr_be[2]) nxt.io_lim_up[7:0]   = wr_data[23:16];
                    if (wr_be[3]) nxt.io_lim_up[15:8]  = wr_data[31:24];
                end
                DW_BCTL: begin
                    if (wr_be[2]) nxt.bctl[7:0]  = wr_data[23:16] & BCTL_WMASK[7:0];
                    if (wr_be[3]) nxt.bctl[15:8] = wr_data[31:24] & BCTL_WMASK[15:8];
                end
                default: ;
            endcase
        end
        if (fwd_disable) begin
            nxt.io_base_a    = '1;
            nxt.io_lim_a     = '0;
            nxt.mem_base_a   = '1;
            nxt.mem_lim_a    = '0;
            nxt.pref_base_a  = '1;
            nxt.pref_lim_a   = '0;
            nxt.pref_base_up = '0;
            nxt.pref_lim_up  = '0;
        end
    end

    // State register with synchronous clear of every stored field.
    always_ff @(posedge clk) begin
        if (!rst_n) regs <= '0;
        else        regs <= nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs.pri == 8'h0 && regs.sec == 8'h0 && regs.sub == 8'h0 &&
                           regs.lat == 8'h0 && regs.bctl == 16'h0 && regs.cmd == 16'h0 &&
                           regs.pref_base_up == 32'h0 && regs.pref_lim_up == 32'h0)); // R1

    AST_DISABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_disable |=> (regs.io_base_a == 4'hF && regs.io_lim_a == 4'h0 &&
                         regs.mem_base_a == 12'hFFF && regs.mem_lim_a == 12'h0 &&
                         regs.pref_base_a == 12'hFFF && regs.pref_lim_a == 12'h0 &&
                         regs.pref_base_up == 32'h0 && regs.pref_lim_up == 32'h0)); // R2

endmodule

// File: rtl/pcib_wr_detect.sv
// Write-side event detection: window-update pulse from per-lane offset match,
// and secondary-bus reset pulse on a 0->1 write of the bus-reset bit.
// Assumes sbr_cur is the stored bus-reset bit before the current edge.
module pcib_wr_detect
    import pcib_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  dw_idx_t    wr_addr,
    input  logic [3:0] wr_be,
    input  logic       sbr_wr_val,
    input  logic       sbr_cur,
    output logic       win_update,
    output logic       sec_bus_rst
);

    logic [3:0] lane_hit;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_lane
            // Per-lane match of the enabled byte against window offsets.
            assign lane_hit[g] = wr_be[g] & lane_in_window({wr_addr, 2'(g)});
        end
    endgenerate

    logic sbr_rise;
    assign sbr_rise = wr_en & (wr_addr == DW_BCTL) & wr_be[2] & sbr_wr_val & ~sbr_cur;

    // Register both pulses so they align with the updated register values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_update  <= 1'b0;
            sec_bus_rst <= 1'b0;
        end else begin
            win_update  <= wr_en & (|lane_hit);
            sec_bus_rst <= sbr_rise;
        end
    end

    AST_WIN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        win_update |-> $past(wr_en && wr_be != 4'h0)); // R5

    AST_SBR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |=> !sec_bus_rst); // R6

    AST_SBR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |-> $past(wr_en && wr_be[2])); // R6

endmodule

// File: rtl/pcib_rd_mux.sv
// Combinational read path: assembles each header dword from stored fields
// and fixed read-only constants; unimplemented dwords read zero.
module pcib_rd_mux
    import pcib_cfg_pkg::*;
#(
    parameter bit MULTI_FN   = 1'b0,
    parameter bit IO_32BIT   = 1'b1,
    parameter bit PREF_64BIT = 1'b1
) (
    input  dw_idx_t      rd_addr,
    input  bridge_regs_t regs,
    output logic [31:0]  rd_data
);

    localparam logic [3:0] IO_TYPE   = IO_32BIT   ? 4'h1 : 4'h0;
    localparam logic [3:0] PREF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;
    localparam logic [7:0] HDR_TYPE  = {MULTI_FN, 7'h01};

    // Dword selection by index.
    always_comb begin
        unique case (rd_addr)
            DW_CMD:   rd_data = {STATUS_CAPS, regs.cmd};
            DW_CLASS: rd_data = {CLASS_P2P, 8'h00};
            DW_HDR:   rd_data = {8'h00, HDR_TYPE, 16'h0000};
            DW_BUS:   rd_data = {regs.lat, regs.sub, regs.sec, regs.pri};
            DW_IO:    rd_data = {STATUS_CAPS, regs.io_lim_a, IO_TYPE, regs.io_base_a, IO_TYPE};
            DW_MEM:   rd_data = {regs.mem_lim_a, 4'h0, regs.mem_base_a, 4'h0};
            DW_PREF:  rd_data = {regs.pref_lim_a, PREF_TYPE, regs.pref_base_a, PREF_TYPE};
            DW_PBUP:  rd_data = regs.pref_base_up;
            DW_PLUP:  rd_data = regs.pref_lim_up;
            DW_IOUP:  rd_data = {regs.io_lim_up, regs.io_base_up};
            DW_BCTL:  rd_data = {regs.bctl, 16'h0000};
            default:  rd_data = 32'h0;
        endcase
    end

endmodule

// File: rtl/pcib_cfg_regs.sv
// Top of the bridge configuration header register file. Ties storage, write
// event detection and read mux together and exports decoded windows.
// Assumes one access per cycle; read data is combinational on cfg_addr.
module pcib_cfg_regs
    import pcib_cfg_pkg::*;
#(
    parameter bit MULTI_FN   = 1'b0,
    parameter bit IO_32BIT   = 1'b1,
    parameter bit PREF_64BIT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW_AW-1:0]     cfg_addr,
    input  logic                 cfg_wr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    input  logic                 fwd_disable,
    output logic [31:0]          cfg_rdata,
    output logic                 win_update,
    output logic                 sec_bus_rst,
    output logic [7:0]           bus_pri,
    output logic [7:0]           bus_sec,
    output logic [7:0]           bus_sub,
    output logic [7:0]           sec_lat,
    output logic [15:0]          cmd_reg,
    output logic [15:0]          bctl_reg,
    output logic [31:0]          io_base,
    output logic [31:0]          io_limit,
    output logic [31:0]          mem_base,
    output logic [31:0]          mem_limit,
    output logic [63:0]          pref_base,
    output logic [63:0]          pref_limit
);

    bridge_regs_t regs;

    pcib_cfg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_addr     (cfg_addr),
        .wr_be       (cfg_be),
        .wr_data     (cfg_wdata),
        .fwd_disable (fwd_disable),
        .regs        (regs)
    );

    pcib_wr_detect u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_addr     (cfg_addr),
        .wr_be       (cfg_be),
        .sbr_wr_val  (cfg_wdata[16 + SBR_BIT]),
        .sbr_cur     (regs.bctl[SBR_BIT]),
        .win_update  (win_update),
        .sec_bus_rst (sec_bus_rst)
    );

    pcib_rd_mux #(
        .MULTI_FN   (MULTI_FN),
        .IO_32BIT   (IO_32BIT),
        .PREF_64BIT (PREF_64BIT)
    ) u_rd (
        .rd_addr (cfg_addr),
        .regs    (regs),
        .rd_data (cfg_rdata)
    );

    // Plain register exports for the window decoder.
    assign bus_pri  = regs.pri;
    assign bus_sec  = regs.sec;
    assign bus_sub  = regs.sub;
    assign sec_lat  = regs.lat;
    assign cmd_reg  = regs.cmd;
    assign bctl_reg = regs.bctl;

    // Window bounds: limits get their granule's low bits filled with ones.
    assign io_base    = {(IO_32BIT ? regs.io_base_up : 16'h0), regs.io_base_a, 12'h000};
    assign io_limit   = {(IO_32BIT ? regs.io_lim_up  : 16'h0), regs.io_lim_a,  12'hFFF};
    assign mem_base   = {regs.mem_base_a, 20'h00000};
    assign mem_limit  = {regs.mem_lim_a,  20'hFFFFF};
    assign pref_base  = {(PREF_64BIT ? regs.pref_base_up : 32'h0), regs.pref_base_a, 20'h00000};
    assign pref_limit = {(PREF_64BIT ? regs.pref_lim_up  : 32'h0), regs.pref_lim_a,  20'hFFFFF};

    AST_SBR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |-> (bctl_reg[SBR_BIT] && !$past(bctl_reg[SBR_BIT]))); // R6

endmodule

// File: tb/tb_pcib_cfg_regs.sv
// Bench: behavioural byte-array model of the header, compared every cycle.
module tb_pcib_cfg_regs;

    localparam bit MF   = 1'b0;
    localparam bit IO32 = 1'b1;
    localparam bit P64  = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fwd_disable = 1'b0;
    logic [31:0] cfg_rdata;
    logic        win_update, sec_bus_rst;
    logic [7:0]  bus_pri, bus_sec, bus_sub, sec_lat;
    logic [15:0] cmd_reg, bctl_reg;
    logic [31:0] io_base, io_limit, mem_base, mem_limit;
    logic [63:0] pref_base, pref_limit;

    always #2 clk = ~clk;

    pcib_cfg_regs #(.MULTI_FN(MF), .IO_32BIT(IO32), .PREF_64BIT(P64)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .fwd_disable(fwd_disable), .cfg_rdata(cfg_rdata),
        .win_update(win_update), .sec_bus_rst(sec_bus_rst), .bus_pri(bus_pri),
        .bus_sec(bus_sec), .bus_sub(bus_sub), .sec_lat(sec_lat), .cmd_reg(cmd_reg),
        .bctl_reg(bctl_reg), .io_base(io_base), .io_limit(io_limit), .mem_base(mem_base),
        .mem_limit(mem_limit), .pref_base(pref_base), .pref_limit(pref_limit)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] mb [0:63];
    logic       e_win = 1'b0;
    logic       e_srst = 1'b0;

    function automatic logic [7:0] wmask(int o);
        if (o == 4) return 8'h47;
        if (o == 5) return 8'h05;
        if (o >= 24 && o <= 27) return 8'hFF;
        if (o == 28 || o == 29) return 8'hF0;
        if (o >= 32 && o <= 39) return (o % 2 == 0) ? 8'hF0 : 8'hFF;
        if (o >= 40 && o <= 51) return 8'hFF;
        if (o == 62) return 8'h7F;
        return 8'h00;
    endfunction

    function automatic logic [7:0] rofix(int o);
        case (o)
            6, 30:   return 8'hA0;
            10:      return 8'h04;
            11:      return 8'h06;
            14:      return {MF, 7'h01};
            28, 29:  return IO32 ? 8'h01 : 8'h00;
            36, 38:  return P64 ? 8'h01 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rb(int o);
        return (mb[o] & wmask(o)) | rofix(o);
    endfunction

    function automatic logic [31:0] rdw(int a);
        return {rb(4*a+3), rb(4*a+2), rb(4*a+1), rb(4*a)};
    endfunction

    function automatic bit in_win(int o);
        return (o == 4 || o == 5 || o == 28 || o == 29 || (o >= 32 && o <= 51) || o == 62 || o == 63);
    endfunction

    // Model update on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < 64; o++) mb[o] = 8'h00;
            e_win = 1'b0;
            e_srst = 1'b0;
        end else begin
            bit hit;
            hit = 0;
            if (cfg_wr)
                for (int i = 0; i < 4; i++)
                    if (cfg_be[i] && in_win(4*cfg_addr + i)) hit = 1;
            e_win  = hit;
            e_srst = cfg_wr && cfg_addr == 4'd15 && cfg_be[2] && cfg_wdata[22] && !mb[62][6];
            if (cfg_wr)
                for (int i = 0; i < 4; i++)
                    if (cfg_be[i]) mb[4*cfg_addr + i] = cfg_wdata[8*i +: 8];
            if (fwd_disable) begin
                mb[28] = 8'hF0; mb[29] = 8'h00;
                mb[32] = 8'hF0; mb[33] = 8'hFF; mb[34] = 8'h00; mb[35] = 8'h00;
                mb[36] = 8'hF0; mb[37] = 8'hFF; mb[38] = 8'h00; mb[39] = 8'h00;
                for (int o = 40; o < 48; o++) mb[o] = 8'h00;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 rdata",       cfg_rdata, rdw(cfg_addr));
            chk("R5 win_update",  win_update, e_win);
            chk("R6 sec_bus_rst", sec_bus_rst, e_srst);
            chk("R7 bus/ctl",     {bus_pri, bus_sec, bus_sub, sec_lat, cmd_reg, bctl_reg},
                {rb(24), rb(25), rb(26), rb(27), rb(5), rb(4), rb(63), rb(62)});
            chk("R7 io_base",  io_base,  {(IO32 ? {rb(49), rb(48)} : 16'h0), rb(28)[7:4], 12'h000});
            chk("R7 io_limit", io_limit, {(IO32 ? {rb(51), rb(50)} : 16'h0), rb(29)[7:4], 12'hFFF});
            chk("R7 mem_base", mem_base,  {rb(33), rb(32)[7:4], 20'h00000});
            chk("R7 mem_limit", mem_limit, {rb(35), rb(34)[7:4], 20'hFFFFF});
            chk("R7 pref_base", pref_base,
                {(P64 ? {rb(43), rb(42), rb(41), rb(40)} : 32'h0), rb(37), rb(36)[7:4], 20'h00000});
            chk("R7 pref_limit", pref_limit,
                {(P64 ? {rb(47), rb(46), rb(45), rb(44)} : 32'h0), rb(39), rb(38)[7:4], 20'hFFFFF});
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] be, logic [31:0] d, logic dis);
        @(posedge clk); #1;
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1; fwd_disable = dis;
        @(posedge clk); #1;
        cfg_wr = 1'b0; fwd_disable = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        chk(tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1 bus/latency", 4'd6, 32'h0);
        rd_chk("R1 bctl", 4'd15, 32'h0);
        rd_chk("R1 io base/limit type kept", 4'd7, 32'h00A0_0101);
        rd_chk("R1 pref upper", 4'd10, 32'h0);
        rd_chk("R1 mem base/limit", 4'd8, 32'h0);
        // R4: read-only fields
        rd_chk("R4 status/cmd", 4'd1, 32'h00A0_0000);
        rd_chk("R4 class", 4'd2, 32'h0604_0000);
        rd_chk("R4 header type", 4'd3, {8'h00, MF, 7'h01, 16'h0});
        rd_chk("R4 unimplemented", 4'd4, 32'h0);
        wr(4'd1, 4'hF, 32'hFFFF_FFFF, 1'b0);
        chk("R5 cmd write pulses", win_update, 1'b1);
        rd_chk("R4 cmd mask, snoop zero", 4'd1, 32'h00A0_0547);
        // R3: byte enables
        wr(4'd6, 4'b0101, 32'h1122_3344, 1'b0);
        chk("R5 bus write no pulse", win_update, 1'b0);
        rd_chk("R3 partial write", 4'd6, 32'h0022_0044);
        wr(4'd1, 4'b0000, 32'hFFFF_FFFF, 1'b0);
        chk("R5 empty enables", win_update, 1'b0);
        wr(4'd12, 4'b1000, 32'hAB00_0000, 1'b0);
        chk("R5 last byte 0x33", win_update, 1'b1);
        rd_chk("R3 upper lane only", 4'd12, 32'hAB00_0000);
        wr(4'd13, 4'hF, 32'hFFFF_FFFF, 1'b0);
        chk("R5 offset 0x34 outside", win_update, 1'b0);
        wr(4'd15, 4'b0001, 32'h0000_00FF, 1'b0);
        chk("R5 offset 0x3C outside", win_update, 1'b0);
        // R6: bus reset edge
        wr(4'd15, 4'b0100, 32'h0040_0000, 1'b0);
        chk("R5 bctl pulse", win_update, 1'b1);
        chk("R6 rise pulse", sec_bus_rst, 1'b1);
        @(negedge clk);
        chk("R6 pulse one cycle", sec_bus_rst, 1'b0);
        wr(4'd15, 4'b0100, 32'h0040_0000, 1'b0);
        chk("R6 already set", sec_bus_rst, 1'b0);
        wr(4'd15, 4'hF, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R4 bctl mask", 4'd15, 32'h007F_0000);
        wr(4'd15, 4'b0100, 32'h0, 1'b0);
        chk("R6 falling no pulse", sec_bus_rst, 1'b0);
        wr(4'd15, 4'b0100, 32'h0040_0000, 1'b0);
        chk("R6 second rise", sec_bus_rst, 1'b1);
        // R2: disable with concurrent write
        wr(4'd8, 4'hF, 32'hFFFF_FFFF, 1'b1);
        chk("R2 mem window", {mem_base, mem_limit}, {32'hFFF0_0000, 32'h000F_FFFF});
        rd_chk("R2 mem regs", 4'd8, 32'h0000_FFF0);
        rd_chk("R2 io regs", 4'd7, 32'h00A0_01F1);
        rd_chk("R2 pref base upper", 4'd10, 32'h0);
        rd_chk("R2 pref limit upper", 4'd11, 32'h0);
        // Mixed traffic checked by the per-cycle model comparison.
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            cfg_addr    = 4'($urandom_range(0, 15));
            cfg_be      = 4'($urandom);
            cfg_wdata   = $urandom;
            cfg_wr      = ($urandom_range(0, 1) == 1);
            fwd_disable = ($urandom_range(0, 15) == 0);
        end
        @(posedge clk); #1;
        cfg_wr = 1'b0; fwd_disable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule